// File: doc/BRIEF.md
# Multipurpose Output Pin Selector

This block drives one general-purpose output pin for each serial channel. A 3-bit select field per channel picks which internal signal appears on that pin. The choices are a request-to-send flag, the counter/timer output, the transmit and receive bit clocks at 1X and 16X, a transmit-ready flag, and a receive-ready or FIFO-full flag. The clock generators, the counter/timer and the FIFOs are outside the block, and their signals arrive as single-bit inputs sampled on the system clock. Each pin is registered, so a change of select takes effect at the next edge and the pin does not glitch.

The request-to-send source is the only stateful one. It is a small two-state machine per channel with the states NEGATED and ASSERTED, and it drives the pin active-low. The transition SET (set command) goes from either state to ASSERTED. From ASSERTED, the transition CLEAR (clear command) returns to NEGATED. So do the transition TX_DRAINED (the transmitter reports its last character fully shifted out while the transmit auto-clear bit is on) and the transition RX_CHOKED (the receive FIFO and the receive shift register are both full while the receive auto-clear bit is on). When SET and any clearing cause occur together, SET wins.

A separate pin-function bit per channel turns a pair of multipurpose pins into outputs. When set, one pin carries transmit-ready and the other carries receive-ready or FIFO-full, and the pair's output enable is high. When clear, the pair is released to serve as inputs.

Top module: `mpo_pins`

## Requirements
- R1: After reset every output pin is high (request-to-send negated), every multipurpose output enable is low, and both multipurpose outputs are low.
- R2: With select 3'b000 the pin shows request-to-send active-low. A set command pulse drives the pin low at the second rising edge after the command, one edge for the flag and one for the pin register.
- R3: A clear command alone returns request-to-send to negated, and the pin goes high with the same two-edge latency.
- R4: While the transmit auto-clear bit is 1, a transmitter-drained pulse negates an asserted request-to-send. While the bit is 0, the pulse has no effect.
- R5: While the receive auto-clear bit is 1, request-to-send is negated when the receive FIFO full and receive shift register full inputs are both 1. One of them alone has no effect, and neither does the pair while the bit is 0.
- R6: A set command in the same cycle as a clear command or any automatic clear leaves request-to-send asserted.
- R7: Select codes route with one edge of latency: 3'b001 counter/timer output, 3'b010 transmit 1X clock, 3'b011 transmit 16X clock, 3'b100 receive 1X clock, 3'b101 receive 16X clock, 3'b110 transmit-ready, 3'b111 receive-ready or FIFO-full.
- R8: For select 3'b011 or 3'b101, if that direction's 4-bit clock-select field equals 4'b1111, the 1X clock of that direction is output in place of the 16X clock.
- R9: With the pin-function bit at 1, multipurpose output A carries transmit-ready, output B carries receive-ready or FIFO-full, and the output enable is 1, each one edge after its inputs. With the bit at 0, the enable and both outputs are 0.
- R10: Channels are independent. Commands, selects and sources of one channel do not change another channel's pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| src_sel | input | 3*NCH | Per-channel source select, channel c at bits [3c+2:3c] |
| rts_set | input | NCH | Request-to-send set command pulse |
| rts_clr | input | NCH | Request-to-send clear command pulse |
| auto_tx_en | input | NCH | Enable auto-clear when transmitter drains |
| auto_rx_en | input | NCH | Enable auto-clear when receive path is full |
| tx_drained | input | NCH | Last transmit character fully shifted out |
| rx_fifo_full | input | NCH | Receive FIFO full |
| rx_shift_full | input | NCH | Receive shift register holds a character |
| ctr_out | input | NCH | Counter/timer output |
| tx_clk1x | input | NCH | Transmit 1X clock |
| tx_clk16x | input | NCH | Transmit 16X clock |
| rx_clk1x | input | NCH | Receive 1X clock |
| rx_clk16x | input | NCH | Receive 16X clock |
| tx_csel | input | 4*NCH | Transmit clock-select field per channel |
| rx_csel | input | 4*NCH | Receive clock-select field per channel |
| tx_ready | input | NCH | Transmitter ready |
| rx_ready_ff | input | NCH | Receiver ready or FIFO full |
| pin_fn | input | NCH | 1 makes the multipurpose pair outputs |
| mpo_pin | output | NCH | Registered general-purpose output pin |
| mpp_a | output | NCH | Multipurpose output A (transmit-ready) |
| mpp_b | output | NCH | Multipurpose output B (receive-ready or FIFO-full) |
| mpp_oe | output | NCH | Output enable for the multipurpose pair |

## Verification
The bench targets the request-to-send corners: set colliding with a clear command and with both automatic clears, where a design giving clears priority would leave the pin high. It also covers a lone FIFO-full or lone shift-full, which must not drop the flag, and a drained pulse with auto-clear disabled. An OR instead of an AND on the receive condition, or an ignored enable bit, shows up as an early pin rise. The 4'b1111 clock-select bypass is exercised in both directions, so a swapped or missing substitution shows a 16X value where a 1X value is expected. Two-edge versus one-edge latency is checked on request-to-send against the other sources, which exposes a missing or extra register stage.

// File: rtl/mpo_pkg.sv
`timescale 1ns/1ps
package mpo_pkg;
    typedef enum logic [2:0] {
        SRC_RTS   = 3'b000,
        SRC_CTR   = 3'b001,
        SRC_TX1X  = 3'b010,
        SRC_TX16X = 3'b011,
        SRC_RX1X  = 3'b100,
        SRC_RX16X = 3'b101,
        SRC_TXRDY = 3'b110,
        SRC_RXRDY = 3'b111
    } mpo_src_t;

    typedef enum logic {
        RTS_NEGATED  = 1'b0,
        RTS_ASSERTED = 1'b1
    } rts_state_t;
endpackage

// File: rtl/mpo_rts_fsm.sv
`timescale 1ns/1ps
module mpo_rts_fsm
    import mpo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic auto_tx_en_i,
    input  logic auto_rx_en_i,
    input  logic tx_drained_i,
    input  logic rx_fifo_full_i,
    input  logic rx_shift_full_i,
    output logic rts_n_o
);
    rts_state_t state_q;
    rts_state_t state_d;
    logic       tx_drop;
    logic       rx_drop;

    assign tx_drop = auto_tx_en_i & tx_drained_i;
    assign rx_drop = auto_rx_en_i & rx_fifo_full_i & rx_shift_full_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RTS_NEGATED;
        else        state_q <= state_d;
    end

    // transitions: SET has top priority, then CLEAR, TX_DRAINED, RX_CHOKED
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RTS_NEGATED: begin
                if (set_i) state_d = RTS_ASSERTED;
            end
            RTS_ASSERTED: begin
                if (set_i)        state_d = RTS_ASSERTED;
                else if (clr_i)   state_d = RTS_NEGATED;
                else if (tx_drop) state_d = RTS_NEGATED;
                else if (rx_drop) state_d = RTS_NEGATED;
            end
            default: state_d = RTS_NEGATED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            RTS_ASSERTED: rts_n_o = 1'b0;
            default:      rts_n_o = 1'b1;
        endcase
    end

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (rts_n_o == 1'b0));
    a_r3_clear_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> (rts_n_o == 1'b1));
    a_r4_tx_auto: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_tx_en_i && tx_drained_i && !set_i) |=> (rts_n_o == 1'b1));
    a_r5_rx_auto: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rx_en_i && rx_fifo_full_i && rx_shift_full_i && !set_i) |=> (rts_n_o == 1'b1));
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i && !(auto_tx_en_i && tx_drained_i) &&
         !(auto_rx_en_i && rx_fifo_full_i && rx_shift_full_i)) |=> $stable(rts_n_o));
endmodule

// File: rtl/mpo_route.sv
`timescale 1ns/1ps
module mpo_route
    import mpo_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int CSR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             rts_n_i,
    input  logic             ctr_i,
    input  logic             tx1x_i,
    input  logic             tx16x_i,
    input  logic             rx1x_i,
    input  logic             rx16x_i,
    input  logic [CSR_W-1:0] tx_csel_i,
    input  logic [CSR_W-1:0] rx_csel_i,
    input  logic             tx_ready_i,
    input  logic             rx_ready_i,
    input  logic             pin_fn_i,
    output logic             pin_o,
    output logic             mpp_a_o,
    output logic             mpp_b_o,
    output logic             mpp_oe_o
);
    localparam logic [CSR_W-1:0] CSEL_BYPASS = {CSR_W{1'b1}};

    logic     tx_fast;
    logic     rx_fast;
    logic     pin_d;
    mpo_src_t src;

    assign src     = mpo_src_t'(sel_i[2:0]);
    assign tx_fast = (tx_csel_i == CSEL_BYPASS) ? tx1x_i : tx16x_i;
    assign rx_fast = (rx_csel_i == CSEL_BYPASS) ? rx1x_i : rx16x_i;

    always_comb begin
        unique case (src)
            SRC_RTS:   pin_d = rts_n_i;
            SRC_CTR:   pin_d = ctr_i;
            SRC_TX1X:  pin_d = tx1x_i;
            SRC_TX16X: pin_d = tx_fast;
            SRC_RX1X:  pin_d = rx1x_i;
            SRC_RX16X: pin_d = rx_fast;
            SRC_TXRDY: pin_d = tx_ready_i;
            SRC_RXRDY: pin_d = rx_ready_i;
            default:   pin_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_o    <= 1'b1;
            mpp_a_o  <= 1'b0;
            mpp_b_o  <= 1'b0;
            mpp_oe_o <= 1'b0;
        end else begin
            pin_o    <= pin_d;
            mpp_a_o  <= pin_fn_i & tx_ready_i;
            mpp_b_o  <= pin_fn_i & rx_ready_i;
            mpp_oe_o <= pin_fn_i;
        end
    end

    a_r7_ctr_path: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'b001) |=> (pin_o == $past(ctr_i)));
    a_r8_tx_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_i == 3'b011) && (tx_csel_i == CSEL_BYPASS)) |=> (pin_o == $past(tx1x_i)));
    a_r9_input_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_fn_i |=> (!mpp_oe_o && !mpp_a_o && !mpp_b_o));
endmodule

// File: rtl/mpo_channel.sv
`timescale 1ns/1ps
module mpo_channel #(
    parameter int SEL_W = 3,
    parameter int CSR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic             auto_tx_en_i,
    input  logic             auto_rx_en_i,
    input  logic             tx_drained_i,
    input  logic             rx_fifo_full_i,
    input  logic             rx_shift_full_i,
    input  logic             ctr_i,
    input  logic             tx1x_i,
    input  logic             tx16x_i,
    input  logic             rx1x_i,
    input  logic             rx16x_i,
    input  logic [CSR_W-1:0] tx_csel_i,
    input  logic [CSR_W-1:0] rx_csel_i,
    input  logic             tx_ready_i,
    input  logic             rx_ready_i,
    input  logic             pin_fn_i,
    output logic             pin_o,
    output logic             mpp_a_o,
    output logic             mpp_b_o,
    output logic             mpp_oe_o
);
    logic rts_n;

    mpo_rts_fsm u_rts (
        .clk            (clk),
        .rst_n          (rst_n),
        .set_i          (set_i),
        .clr_i          (clr_i),
        .auto_tx_en_i   (auto_tx_en_i),
        .auto_rx_en_i   (auto_rx_en_i),
        .tx_drained_i   (tx_drained_i),
        .rx_fifo_full_i (rx_fifo_full_i),
        .rx_shift_full_i(rx_shift_full_i),
        .rts_n_o        (rts_n)
    );

    mpo_route #(.SEL_W(SEL_W), .CSR_W(CSR_W)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel_i),
        .rts_n_i   (rts_n),
        .ctr_i     (ctr_i),
        .tx1x_i    (tx1x_i),
        .tx16x_i   (tx16x_i),
        .rx1x_i    (rx1x_i),
        .rx16x_i   (rx16x_i),
        .tx_csel_i (tx_csel_i),
        .rx_csel_i (rx_csel_i),
        .tx_ready_i(tx_ready_i),
        .rx_ready_i(rx_ready_i),
        .pin_fn_i  (pin_fn_i),
        .pin_o     (pin_o),
        .mpp_a_o   (mpp_a_o),
        .mpp_b_o   (mpp_b_o),
        .mpp_oe_o  (mpp_oe_o)
    );
endmodule

// File: rtl/mpo_pins.sv
`timescale 1ns/1ps
module mpo_pins #(
    parameter int NCH   = 2,
    parameter int SEL_W = 3,
    parameter int CSR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W*NCH-1:0] src_sel,
    input  logic [NCH-1:0]     rts_set,
    input  logic [NCH-1:0]     rts_clr,
    input  logic [NCH-1:0]     auto_tx_en,
    input  logic [NCH-1:0]     auto_rx_en,
    input  logic [NCH-1:0]     tx_drained,
    input  logic [NCH-1:0]     rx_fifo_full,
    input  logic [NCH-1:0]     rx_shift_full,
    input  logic [NCH-1:0]     ctr_out,
    input  logic [NCH-1:0]     tx_clk1x,
    input  logic [NCH-1:0]     tx_clk16x,
    input  logic [NCH-1:0]     rx_clk1x,
    input  logic [NCH-1:0]     rx_clk16x,
    input  logic [CSR_W*NCH-1:0] tx_csel,
    input  logic [CSR_W*NCH-1:0] rx_csel,
    input  logic [NCH-1:0]     tx_ready,
    input  logic [NCH-1:0]     rx_ready_ff,
    input  logic [NCH-1:0]     pin_fn,
    output logic [NCH-1:0]     mpo_pin,
    output logic [NCH-1:0]     mpp_a,
    output logic [NCH-1:0]     mpp_b,
    output logic [NCH-1:0]     mpp_oe
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        mpo_channel #(.SEL_W(SEL_W), .CSR_W(CSR_W)) u_ch (
            .clk            (clk),
            .rst_n          (rst_n),
            .sel_i          (src_sel[c*SEL_W +: SEL_W]),
            .set_i          (rts_set[c]),
            .clr_i          (rts_clr[c]),
            .auto_tx_en_i   (auto_tx_en[c]),
            .auto_rx_en_i   (auto_rx_en[c]),
            .tx_drained_i   (tx_drained[c]),
            .rx_fifo_full_i (rx_fifo_full[c]),
            .rx_shift_full_i(rx_shift_full[c]),
            .ctr_i          (ctr_out[c]),
            .tx1x_i         (tx_clk1x[c]),
            .tx16x_i        (tx_clk16x[c]),
            .rx1x_i         (rx_clk1x[c]),
            .rx16x_i        (rx_clk16x[c]),
            .tx_csel_i      (tx_csel[c*CSR_W +: CSR_W]),
            .rx_csel_i      (rx_csel[c*CSR_W +: CSR_W]),
            .tx_ready_i     (tx_ready[c]),
            .rx_ready_i     (rx_ready_ff[c]),
            .pin_fn_i       (pin_fn[c]),
            .pin_o          (mpo_pin[c]),
            .mpp_a_o        (mpp_a[c]),
            .mpp_b_o        (mpp_b[c]),
            .mpp_oe_o       (mpp_oe[c])
        );
    end

    a_r1_reset_pin: assert property (@(posedge clk)
        !rst_n |=> (mpp_oe == '0));
endmodule

// File: tb/mpo_pins_test.sv
`timescale 1ns/1ps
module mpo_pins_test;
    localparam int NCH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [3*NCH-1:0] src_sel = '0;
    logic [NCH-1:0] rts_set = '0, rts_clr = '0, auto_tx_en = '0, auto_rx_en = '0;
    logic [NCH-1:0] tx_drained = '0, rx_fifo_full = '0, rx_shift_full = '0, ctr_out = '0;
    logic [NCH-1:0] tx_clk1x = '0, tx_clk16x = '0, rx_clk1x = '0, rx_clk16x = '0;
    logic [4*NCH-1:0] tx_csel = '0, rx_csel = '0;
    logic [NCH-1:0] tx_ready = '0, rx_ready_ff = '0, pin_fn = '0;
    logic [NCH-1:0] mpo_pin, mpp_a, mpp_b, mpp_oe;

    mpo_pins #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .rts_set(rts_set), .rts_clr(rts_clr),
        .auto_tx_en(auto_tx_en), .auto_rx_en(auto_rx_en), .tx_drained(tx_drained),
        .rx_fifo_full(rx_fifo_full), .rx_shift_full(rx_shift_full), .ctr_out(ctr_out),
        .tx_clk1x(tx_clk1x), .tx_clk16x(tx_clk16x), .rx_clk1x(rx_clk1x), .rx_clk16x(rx_clk16x),
        .tx_csel(tx_csel), .rx_csel(rx_csel), .tx_ready(tx_ready), .rx_ready_ff(rx_ready_ff),
        .pin_fn(pin_fn), .mpo_pin(mpo_pin), .mpp_a(mpp_a), .mpp_b(mpp_b), .mpp_oe(mpp_oe)
    );

    typedef struct {
        logic [NCH-1:0] pin;
        logic [NCH-1:0] a;
        logic [NCH-1:0] b;
        logic [NCH-1:0] oe;
        string          tag;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    logic [NCH-1:0] m_rts = '0;   // model: 1 = request-to-send asserted

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    function automatic logic route(input int c);
        logic [2:0] s;
        s = src_sel[c*3 +: 3];
        case (s)
            3'b000: return ~m_rts[c];
            3'b001: return ctr_out[c];
            3'b010: return tx_clk1x[c];
            3'b011: return (tx_csel[c*4 +: 4] == 4'hF) ? tx_clk1x[c] : tx_clk16x[c];
            3'b100: return rx_clk1x[c];
            3'b101: return (rx_csel[c*4 +: 4] == 4'hF) ? rx_clk1x[c] : rx_clk16x[c];
            3'b110: return tx_ready[c];
            default: return rx_ready_ff[c];
        endcase
    endfunction

    // driver: inputs are set at a falling edge; push expected value for the next rising edge
    task automatic step(input string tag);
        exp_t e;
        for (int c = 0; c < NCH; c++) begin
            e.pin[c] = route(c);
            e.a[c]   = pin_fn[c] & tx_ready[c];
            e.b[c]   = pin_fn[c] & rx_ready_ff[c];
            e.oe[c]  = pin_fn[c];
        end
        e.tag = tag;
        sb.push_back(e);
        for (int c = 0; c < NCH; c++) begin
            if (rts_set[c]) m_rts[c] = 1'b1;
            else if (rts_clr[c]) m_rts[c] = 1'b0;
            else if ((auto_tx_en[c] && tx_drained[c]) ||
                     (auto_rx_en[c] && rx_fifo_full[c] && rx_shift_full[c])) m_rts[c] = 1'b0;
        end
        @(negedge clk);
    endtask

    // monitor: pops after each rising edge once outputs have settled
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(mpo_pin === e.pin, e.tag, "mpo_pin", mpo_pin, e.pin);
            check(mpp_a === e.a && mpp_b === e.b && mpp_oe === e.oe, e.tag, "mpp a|b|oe",
                  {mpp_a, mpp_b, mpp_oe}[NCH-1:0] ^ {mpp_a ^ e.a}, e.oe);
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(mpo_pin === '1, "R1", "pin", mpo_pin, '1);
        check(mpp_oe === '0 && mpp_a === '0 && mpp_b === '0, "R1", "mpp", mpp_oe | mpp_a | mpp_b, '0);
        rst_n = 1'b1;
        @(negedge clk);
        step("R1 idle after reset");

        // R7: every non-RTS select, distinct patterns on the two channels
        ctr_out = 2'b01; tx_clk1x = 2'b10; tx_clk16x = 2'b01; rx_clk1x = 2'b01;
        rx_clk16x = 2'b10; tx_ready = 2'b01; rx_ready_ff = 2'b10;
        tx_csel = {4'h3, 4'h5}; rx_csel = {4'h2, 4'hB};
        for (int s = 1; s < 8; s++) begin
            src_sel = {3'(8 - s), 3'(s)};
            step("R7 route");
            ctr_out = ~ctr_out; tx_clk1x = ~tx_clk1x; rx_clk16x = ~rx_clk16x;
            step("R7 route toggled");
        end

        // R8: clock-select bypass
        tx_csel = {4'hF, 4'hF}; rx_csel = {4'hF, 4'hF};
        tx_clk1x = 2'b11; tx_clk16x = 2'b00; rx_clk1x = 2'b00; rx_clk16x = 2'b11;
        src_sel = {3'b101, 3'b011};
        step("R8 bypass tx ch0 rx ch1");
        src_sel = {3'b011, 3'b101};
        step("R8 bypass rx ch0 tx ch1");
        tx_csel = {4'hE, 4'h7};
        src_sel = {3'b011, 3'b011};
        step("R8 no bypass");

        // R2 / R3: set then clear, channel 0 only, channel 1 watches R10
        src_sel = 6'b000_000;
        step("R2 idle");
        rts_set = 2'b01; step("R2 set");
        rts_set = 2'b00; step("R2 latency");
        step("R10 ch1 untouched");
        rts_clr = 2'b01; step("R3 clear");
        rts_clr = 2'b00; step("R3 latency");
        step("R3 settled");

        // R4: drained pulse ignored while disabled, honoured while enabled
        rts_set = 2'b11; step("R4 set both");
        rts_set = 2'b00; tx_drained = 2'b01; step("R4 disabled pulse");
        tx_drained = 2'b00; step("R4 still asserted");
        auto_tx_en = 2'b01; tx_drained = 2'b01; step("R4 enabled pulse");
        tx_drained = 2'b00; step("R4 pin rises");
        step("R10 ch1 still asserted");

        // R5: receive-full auto clear
        auto_tx_en = 2'b00;
        rts_set = 2'b01; step("R5 set ch0");
        rts_set = 2'b00; auto_rx_en = 2'b11;
        rx_fifo_full = 2'b01; step("R5 fifo only");
        rx_fifo_full = 2'b00; rx_shift_full = 2'b01; step("R5 shift only");
        rx_shift_full = 2'b00; step("R5 held");
        auto_rx_en = 2'b00; rx_fifo_full = 2'b11; rx_shift_full = 2'b11; step("R5 disabled both full");
        rx_fifo_full = 2'b00; rx_shift_full = 2'b00; step("R5 held 2");
        auto_rx_en = 2'b01; rx_fifo_full = 2'b01; rx_shift_full = 2'b01; step("R5 both full");
        rx_fifo_full = 2'b00; rx_shift_full = 2'b00; auto_rx_en = 2'b00; step("R5 pin rises");
        step("R5 settled");

        // R6: set collides with every clearing cause
        rts_set = 2'b11; rts_clr = 2'b11; auto_tx_en = 2'b11; tx_drained = 2'b11;
        auto_rx_en = 2'b11; rx_fifo_full = 2'b11; rx_shift_full = 2'b11;
        step("R6 collision");
        rts_set = 2'b00; rts_clr = 2'b00; tx_drained = 2'b00;
        rx_fifo_full = 2'b00; rx_shift_full = 2'b00; auto_tx_en = 2'b00; auto_rx_en = 2'b00;
        step("R6 asserted");
        step("R6 held");
        rts_clr = 2'b10; step("R10 clear ch1 only");
        rts_clr = 2'b00; step("R10 ch0 kept");
        step("R10 settled");

        // R9: pin-function bit
        tx_ready = 2'b01; rx_ready_ff = 2'b10;
        pin_fn = 2'b11; step("R9 outputs on");
        tx_ready = 2'b10; rx_ready_ff = 2'b01; step("R9 follow");
        pin_fn = 2'b01; step("R9 ch1 released");
        pin_fn = 2'b00; step("R9 all released");
        step("R9 settled");

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule